// File: doc/BRIEF.md
# ROM Patch Address Substitution Unit

This unit sits between a processor's 16-bit address bus and its program memories. It lets a small number of locations in a fixed main ROM be corrected after manufacture. It holds a table of eight patch entries. Each entry names an aligned 8-byte block of the address space and gives the 8-bit location in a separate patch memory that serves that block.

When the processor presents a valid address, the unit compares the upper thirteen address bits with every valid entry. On a hit it pulls its active-low flag low. It then replaces address bits 10..3 on the buffered bus with the entry's replacement field, turns off the main ROM select and turns on the patch memory select. On a miss the address passes through unchanged and the main ROM is selected. The address lines that take no part in the substitution are always copied straight through.

Table entries are written through a simple port: an index, the entry contents and a write strobe. Matching is purely combinational from the address inputs. The only clocked state is the table. The unit has no state machine, so it has no states or transitions to list.

Top module: `rom_patch_sub`

## Requirements
- R1: An entry hits when its valid bit is set and its 13-bit match field equals cpu_addr[15:3]. Bit k of the match field corresponds to address bit k+3, and cpu_addr[2:0] never affects the result.
- R2: bus_addr[2:0] and bus_addr[15:11] always equal the same bits of cpu_addr, whether or not an entry hits.
- R3: When no entry hits, flag_n is 1 and bus_addr[10:3] equals cpu_addr[10:3].
- R4: When an entry hits, flag_n is 0 and bus_addr[10:3] equals the replacement field of the winning entry. Bit j of the replacement field drives bus_addr[j+3].
- R5: With vma=1 and force_n=1, a hit gives rom_cs=0 and patch_cs=1, and a miss gives rom_cs=1 and patch_cs=0.
- R6: While vma=0 no entry hits, flag_n is 1, and both rom_cs and patch_cs are 0.
- R7: While force_n=0, rom_cs, patch_cs and ram_path_en are all 0. While force_n=1, ram_path_en is 1.
- R8: When several valid entries hit, the entry with the lowest index supplies the replacement field.
- R9: When wr_en=1 at a rising clk edge, entry wr_idx takes wr_valid, wr_match and wr_repl. The new contents decide matching from that edge on.
- R10: A synchronous reset (rst=1 at a clk edge) clears every valid bit, so no address hits until an entry is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes and reset |
| rst | input | 1 | Synchronous reset, active high, clears all valid bits |
| cpu_addr | input | 16 | Address from the processor |
| vma | input | 1 | High when cpu_addr is a genuine memory address |
| force_n | input | 1 | Maintenance input, active low, disables memory selection |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Index of the entry to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_match | input | 13 | Match field: address bits 15..3 |
| wr_repl | input | 8 | Replacement field for bus bits 10..3 |
| bus_addr | output | 16 | Buffered address with substitution applied |
| flag_n | output | 1 | Low when a patch entry hits |
| rom_cs | output | 1 | Main ROM select, active high |
| patch_cs | output | 1 | Patch memory select, active high |
| ram_path_en | output | 1 | Permission for the RAM selection path |

## Verification
The main function is tried with several kinds of address:
- Addresses drawn at random across the whole space. These almost always miss, and they show that the address passes through untouched.
- Addresses built from a stored match field with random low bits. These show that bits 2..0 are ignored and that exactly bits 10..3 are replaced.
- An invalid entry whose match field equals the address. This separates the valid bit from the field comparison.
- Two valid entries that share a match field. This shows which index wins.

Dropping vma and dropping force_n on a hit address separate those two gating paths from the comparison. A reset taken after the table is loaded shows that the valid bits are cleared.

// File: rtl/rps_pkg.sv
package rps_pkg;
    localparam int ADDR_W   = 16;
    localparam int MID_LO   = 3;
    localparam int MID_HI   = 10;
    localparam int ENTRIES  = 8;
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int KEY_W    = ADDR_W - MID_LO;
    localparam int REPL_W   = MID_HI - MID_LO + 1;
endpackage

// File: rtl/rps_table.sv
module rps_table #(
    parameter int N     = 8,
    parameter int IW    = 3,
    parameter int MW    = 13,
    parameter int RW    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic                  wr_valid,
    input  logic [MW-1:0]         wr_match,
    input  logic [RW-1:0]         wr_repl,
    output logic [N-1:0]          ent_valid,
    output logic [N-1:0][MW-1:0]  ent_match,
    output logic [N-1:0][RW-1:0]  ent_repl
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[g] <= 1'b0;
            end else if (sel) begin
                ent_valid[g] <= wr_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                ent_match[g] <= wr_match;
                ent_repl[g]  <= wr_repl;
            end
        end
    end
endmodule

// File: rtl/rps_match.sv
module rps_match #(
    parameter int N  = 8,
    parameter int MW = 13,
    parameter int RW = 8
) (
    input  logic [MW-1:0]         key,
    input  logic                  qualify,
    input  logic [N-1:0]          ent_valid,
    input  logic [N-1:0][MW-1:0]  ent_match,
    input  logic [N-1:0][RW-1:0]  ent_repl,
    output logic                  hit,
    output logic [RW-1:0]         repl
);
    logic [N-1:0] raw;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign raw[g] = ent_valid[g] && (ent_match[g] == key);
    end

    // scan from the top so the lowest index is the last to overwrite
    always_comb begin
        hit  = 1'b0;
        repl = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (raw[i]) begin
                hit  = 1'b1;
                repl = ent_repl[i];
            end
        end
        if (!qualify) begin
            hit  = 1'b0;
            repl = '0;
        end
    end
endmodule

// File: rtl/rom_patch_sub.sv
module rom_patch_sub
    import rps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 vma,
    input  logic                 force_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_valid,
    input  logic [KEY_W-1:0]     wr_match,
    input  logic [REPL_W-1:0]    wr_repl,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 flag_n,
    output logic                 rom_cs,
    output logic                 patch_cs,
    output logic                 ram_path_en
);
    logic [ENTRIES-1:0]             t_valid;
    logic [ENTRIES-1:0][KEY_W-1:0]  t_match;
    logic [ENTRIES-1:0][REPL_W-1:0] t_repl;
    logic                           hit;
    logic [REPL_W-1:0]              sub_bits;

    rps_table #(.N(ENTRIES), .IW(IDX_W), .MW(KEY_W), .RW(REPL_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_match  (wr_match),
        .wr_repl   (wr_repl),
        .ent_valid (t_valid),
        .ent_match (t_match),
        .ent_repl  (t_repl)
    );

    rps_match #(.N(ENTRIES), .MW(KEY_W), .RW(REPL_W)) u_match (
        .key       (cpu_addr[ADDR_W-1:MID_LO]),
        .qualify   (vma),
        .ent_valid (t_valid),
        .ent_match (t_match),
        .ent_repl  (t_repl),
        .hit       (hit),
        .repl      (sub_bits)
    );

    always_comb begin
        bus_addr               = cpu_addr;
        if (hit) begin
            bus_addr[MID_HI:MID_LO] = sub_bits;
        end
        flag_n      = !hit;
        rom_cs      = vma && !hit && force_n;
        patch_cs    = hit && force_n;
        ram_path_en = force_n;
    end
endmodule

// File: rtl/rps_chk.sv
module rps_chk
    import rps_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              vma,
    input logic              force_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              flag_n,
    input logic              rom_cs,
    input logic              patch_cs,
    input logic              ram_path_en
);
    // R2
    fwd_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[MID_LO-1:0] == cpu_addr[MID_LO-1:0]) &&
        (bus_addr[ADDR_W-1:MID_HI+1] == cpu_addr[ADDR_W-1:MID_HI+1]));

    // R3
    miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
        flag_n |-> (bus_addr[MID_HI:MID_LO] == cpu_addr[MID_HI:MID_LO]));

    // R5
    hit_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_n |-> !rom_cs);

    // R6
    vma_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !vma |-> (flag_n && !rom_cs && !patch_cs));

    // R7
    force_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !force_n |-> (!rom_cs && !patch_cs && !ram_path_en));

    // R5
    cs_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({rom_cs, patch_cs}) <= 1);

    // R10
    post_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> flag_n);
endmodule

bind rom_patch_sub rps_chk u_chk (.*);

// File: tb/sim_rom_patch_sub.sv
module sim_rom_patch_sub;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        vma;
    logic        force_n;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic        wr_valid;
    logic [12:0] wr_match;
    logic [7:0]  wr_repl;
    logic [15:0] bus_addr;
    logic        flag_n, rom_cs, patch_cs, ram_path_en;

    int checks = 0;
    int errors = 0;

    bit          m_valid [8];
    logic [12:0] m_match [8];
    logic [7:0]  m_repl  [8];

    always #10 clk = ~clk;

    rom_patch_sub u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .vma(vma), .force_n(force_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_match(wr_match),
        .wr_repl(wr_repl), .bus_addr(bus_addr), .flag_n(flag_n), .rom_cs(rom_cs),
        .patch_cs(patch_cs), .ram_path_en(ram_path_en)
    );

    function automatic int find_hit(logic [15:0] a, bit v);
        if (!v) return -1;
        for (int i = 0; i < 8; i++)
            if (m_valid[i] && m_match[i] == a[15:3]) return i;
        return -1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        int h;
        logic [15:0] eb;
        h  = find_hit(cpu_addr, vma);
        eb = cpu_addr;
        if (h >= 0) eb[10:3] = m_repl[h];
        chk({tag, " R2 fwd"}, {16'b0, bus_addr[15:11], 8'b0, bus_addr[2:0]},
                              {16'b0, eb[15:11], 8'b0, eb[2:0]});
        chk({tag, (h >= 0) ? " R4 mid" : " R3 mid"}, {24'b0, bus_addr[10:3]}, {24'b0, eb[10:3]});
        chk({tag, " R1 flag"}, {31'b0, flag_n}, {31'b0, !(h >= 0)});
        chk({tag, " R5 cs"}, {30'b0, rom_cs, patch_cs},
            {30'b0, vma && force_n && h < 0, force_n && h >= 0});
        chk({tag, " R7 ram"}, {31'b0, ram_path_en}, {31'b0, force_n});
    endtask

    task automatic apply(logic [15:0] a, logic v, logic f, string tag);
        @(negedge clk);
        cpu_addr = a; vma = v; force_n = f;
        #2;
        check_outputs(tag);
    endtask

    // R9 write task: model updates at the same edge as the table
    task automatic write_ent(int idx, bit v, logic [12:0] m, logic [7:0] r);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_valid = v; wr_match = m; wr_repl = r;
        @(posedge clk);
        m_valid[idx] = v; m_match[idx] = m; m_repl[idx] = r;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cpu_addr = '0; vma = 1'b0; force_n = 1'b1;
        wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_match = '0; wr_repl = '0;
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 1'b0; m_match[i] = '0; m_repl[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state, nothing matches
        apply(16'h0000, 1'b1, 1'b1, "R10 reset");
        apply(16'hFFFF, 1'b1, 1'b1, "R10 reset");

        // R9: load entries
        write_ent(0, 1'b1, 13'h1234, 8'hA5);
        write_ent(1, 1'b0, 13'h0ABC, 8'h3C);   // invalid entry
        write_ent(2, 1'b1, 13'h1F00, 8'h11);
        write_ent(5, 1'b1, 13'h1F00, 8'h77);   // duplicate, higher index
        write_ent(7, 1'b1, 13'h0001, 8'hFF);

        // R1: all low-bit offsets in one block hit
        for (int k = 0; k < 8; k++)
            apply({13'h1234, 3'(k)}, 1'b1, 1'b1, "R1 block");
        // R1: invalid entry ignored
        apply({13'h0ABC, 3'd5}, 1'b1, 1'b1, "R1 invalid");
        // R8: lowest index wins
        apply({13'h1F00, 3'd2}, 1'b1, 1'b1, "R8 prio");
        chk("R8 repl", {24'b0, bus_addr[10:3]}, 32'h11);
        // R6: vma low blocks a hit
        apply({13'h1234, 3'd0}, 1'b0, 1'b1, "R6 vma");
        // R7: forced mode
        apply({13'h1234, 3'd0}, 1'b1, 1'b0, "R7 force hit");
        apply(16'h4000, 1'b1, 1'b0, "R7 force miss");
        // R9: overwrite entry 2, entry 5 now wins
        write_ent(2, 1'b0, 13'h1F00, 8'h11);
        apply({13'h1F00, 3'd6}, 1'b1, 1'b1, "R9 rewrite");
        chk("R9 repl", {24'b0, bus_addr[10:3]}, 32'h77);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            if ($urandom_range(1, 0) == 1) begin
                int e;
                e = int'($urandom_range(7, 0));
                a = {m_match[e], 3'($urandom)};
            end else begin
                a = 16'($urandom);
            end
            if ($urandom_range(15, 0) == 0)
                write_ent(int'($urandom_range(7, 0)), 1'($urandom), 13'($urandom), 8'($urandom));
            apply(a, ($urandom_range(7, 0) != 0), ($urandom_range(7, 0) != 0), "RND");
        end

        // R10: reset clears loaded table
        write_ent(3, 1'b1, 13'h0777, 8'h42);
        apply({13'h0777, 3'd1}, 1'b1, 1'b1, "R10 pre");
        do_reset();
        apply({13'h0777, 3'd1}, 1'b1, 1'b1, "R10 post");
        chk("R10 flag", {31'b0, flag_n}, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule